// File: doc/BRIEF.md
# Interleaved I/Q Word Port

This block receives baseband samples for a quadrature upconverter over one shared parallel bus. In-phase and quadrature words take turns on that bus. The block makes a word-rate strobe from the system clock, and on each strobe cycle it takes one word, provided the transmit-enable input is high. It then hands each completed I/Q pair downstream as one parallel sample, together with a single-cycle valid pulse.

The word strobe fires once every 2R system-clock cycles, where R is the programmable interpolation factor. Each of the I and Q streams therefore advances once every 4R cycles. Input words may be coded as two's complement or as offset binary. Either way, the output is always two's complement.

Pairing restarts from I each time transmit-enable rises. If enable is withdrawn while an I word is still waiting for its Q partner, that I word is thrown away and an error pulse is raised.

Top module: `iq_word_port`

## Requirements
- R1: `word_ce` is high for exactly one system-clock cycle out of every 2R cycles, for any `interp_r` value R from 2 to 63.
- R2: An `interp_r` value of 0 or 1 produces the same strobe period as R = 2, which is 4 cycles.
- R3: A word is taken only in a cycle where both `word_ce` and `tx_en` are high. Words present while `tx_en` is low have no effect on any output.
- R4: The first word taken after `tx_en` rises is the I word, and the next word taken is its Q partner.
- R5: `out_valid` goes high for exactly one cycle, in the cycle right after the clock edge that took the Q word. In that same cycle, `i_out` and `q_out` carry the pair.
- R6: When `fmt_offset` is 0, words pass through to the outputs unchanged.
- R7: When `fmt_offset` is 1, bit 17 of each word is inverted and the other bits pass through unchanged.
- R8: If `tx_en` is low while an I word waits for its Q partner, that I word is discarded and `orphan_err` pulses for one cycle. The next pair then starts again from I.
- R9: During reset, `word_ce`, `out_valid`, `orphan_err`, `i_out` and `q_out` are all 0.
- R10: `i_out` and `q_out` hold their values in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interp_r | input | 6 | Interpolation factor R (2..63) |
| fmt_offset | input | 1 | 1 = offset-binary input, 0 = two's complement |
| tx_en | input | 1 | Transmit-enable strobe qualifying the bus |
| data_in | input | 18 | Shared interleaved I/Q word bus |
| word_ce | output | 1 | Word-rate strobe, one cycle in every 2R |
| i_out | output | 18 | In-phase sample, two's complement |
| q_out | output | 18 | Quadrature sample, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new pair |
| orphan_err | output | 1 | One-cycle pulse when an unpaired I word is dropped |

## Verification
A divider counter that drifts would show up on the very next strobe, as a gap between `word_ce` pulses that is not 2R. A pairing state that slips by one word would show up on the first `out_valid` after enable rises, with I and Q swapped or taken from different pairs. A pairing state left stale after enable falls would either fail to raise `orphan_err` within one cycle or corrupt the next pair. A wrong format path would show up as a flipped or unflipped bit 17 on the first output sample.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;

  typedef enum logic {
    PAIR_WANT_I = 1'b0,
    PAIR_WANT_Q = 1'b1
  } pair_state_e;

endpackage

// File: rtl/iq_rate_div.sv
module iq_rate_div #(
  parameter int R_W   = 6,
  parameter int R_MIN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] interp_r,
  output logic           ce_o
);
  localparam int CNT_W = R_W + 1;

  logic [R_W-1:0]   r_eff;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Factors below the minimum behave as the minimum.
  always_comb begin
    r_eff = (interp_r < R_W'(R_MIN)) ? R_W'(R_MIN) : interp_r;
    lim   = {r_eff, 1'b0} - CNT_W'(1);
  end

  // Wrap when the limit is reached or passed, e.g. after R shrinks mid-count.
  always_comb begin
    if (cnt_q >= lim) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ce_o = (cnt_q == lim);

endmodule

// File: rtl/iq_word_fmt.sv
module iq_word_fmt #(
  parameter int WORD_W = 18
) (
  input  logic              fmt_offset,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  // Offset binary becomes two's complement by flipping the sign bit.
  always_comb begin
    word_o = word_i;
    if (fmt_offset) word_o[WORD_W-1] = ~word_i[WORD_W-1];
  end

endmodule

// File: rtl/iq_pair_asm.sv
module iq_pair_asm
  import iq_port_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              tx_en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] i_out,
  output logic [WORD_W-1:0] q_out,
  output logic              out_valid,
  output logic              orphan_err
);
  pair_state_e       st_q, st_d;
  logic [WORD_W-1:0] ihold_q, ihold_d;
  logic [WORD_W-1:0] iout_q, iout_d;
  logic [WORD_W-1:0] qout_q, qout_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  always_comb begin
    st_d    = st_q;
    ihold_d = ihold_q;
    iout_d  = iout_q;
    qout_d  = qout_q;
    vld_d   = 1'b0;
    err_d   = 1'b0;
    if (!tx_en) begin
      // Enable gone: any waiting I word is dropped.
      if (st_q == PAIR_WANT_Q) err_d = 1'b1;
      st_d = PAIR_WANT_I;
    end else if (ce) begin
      if (st_q == PAIR_WANT_I) begin
        ihold_d = word;
        st_d    = PAIR_WANT_Q;
      end else begin
        iout_d = ihold_q;
        qout_d = word;
        vld_d  = 1'b1;
        st_d   = PAIR_WANT_I;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PAIR_WANT_I;
      ihold_q <= '0;
      iout_q  <= '0;
      qout_q  <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ihold_q <= ihold_d;
      iout_q  <= iout_d;
      qout_q  <= qout_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  assign i_out      = iout_q;
  assign q_out      = qout_q;
  assign out_valid  = vld_q;
  assign orphan_err = err_q;

endmodule

// File: rtl/iq_word_port.sv
module iq_word_port #(
  parameter int WORD_W = 18,
  parameter int R_W    = 6,
  parameter int R_MIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [R_W-1:0]    interp_r,
  input  logic              fmt_offset,
  input  logic              tx_en,
  input  logic [WORD_W-1:0] data_in,
  output logic              word_ce,
  output logic [WORD_W-1:0] i_out,
  output logic [WORD_W-1:0] q_out,
  output logic              out_valid,
  output logic              orphan_err
);
  logic [WORD_W-1:0] word_tc;

  iq_rate_div #(.R_W(R_W), .R_MIN(R_MIN)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .interp_r (interp_r),
    .ce_o     (word_ce)
  );

  iq_word_fmt #(.WORD_W(WORD_W)) u_fmt (
    .fmt_offset (fmt_offset),
    .word_i     (data_in),
    .word_o     (word_tc)
  );

  iq_pair_asm #(.WORD_W(WORD_W)) u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (word_ce),
    .tx_en      (tx_en),
    .word       (word_tc),
    .i_out      (i_out),
    .q_out      (q_out),
    .out_valid  (out_valid),
    .orphan_err (orphan_err)
  );

endmodule

// File: rtl/iq_word_port_chk.sv
module iq_word_port_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_ce,
  input logic              tx_en,
  input logic [WORD_W-1:0] i_out,
  input logic [WORD_W-1:0] q_out,
  input logic              out_valid,
  input logic              orphan_err
);
  // Strobe period is at least four cycles, so a strobe never repeats at once.
  p_ce_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_ce |=> !word_ce);

  p_valid_from_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(word_ce && tx_en));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_err |=> !orphan_err);

  p_err_after_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_err |-> !$past(tx_en));

  p_err_not_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(orphan_err && out_valid));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(i_out) && $stable(q_out)));

endmodule

bind iq_word_port iq_word_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_ce    (word_ce),
  .tx_en      (tx_en),
  .i_out      (i_out),
  .q_out      (q_out),
  .out_valid  (out_valid),
  .orphan_err (orphan_err)
);

// File: tb/iq_word_port_bench.sv
`timescale 1ns/1ps
module iq_word_port_bench;
  logic        clk;
  logic        rst_n;
  logic [5:0]  interp_r;
  logic        fmt_offset;
  logic        tx_en;
  logic [17:0] data_in;
  logic        word_ce;
  logic [17:0] i_out;
  logic [17:0] q_out;
  logic        out_valid;
  logic        orphan_err;

  int total = 0;
  int bad   = 0;
  int vld_seen = 0;
  int err_seen = 0;
  bit done = 0;

  iq_word_port u_iq_word_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .interp_r   (interp_r),
    .fmt_offset (fmt_offset),
    .tx_en      (tx_en),
    .data_in    (data_in),
    .word_ce    (word_ce),
    .i_out      (i_out),
    .q_out      (q_out),
    .out_valid  (out_valid),
    .orphan_err (orphan_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && out_valid)  vld_seen++;
    if (rst_n && orphan_err) err_seen++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Returns at the falling edge after the capturing rising edge.
  task automatic put_word(input logic [17:0] w);
    data_in = w;
    while (word_ce !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sync_ce();
    while (word_ce !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_period(input int r, input int expp);
    int n;
    interp_r = 6'(r);
    sync_ce();
    sync_ce();
    n = 1;
    while (word_ce !== 1'b1) begin @(negedge clk); n++; end
    @(negedge clk);
    check(n == expp, (r < 2) ? "R2 period clamp" : "R1 period", n, expp);
  endtask

  function automatic logic [17:0] pick(input int k);
    case (k)
      0: return 18'h00000;
      1: return 18'h1FFFF;
      2: return 18'h20000;
      3: return 18'h3FFFF;
      default: return 18'((k * 10923 + 17) & 18'h3FFFF);
    endcase
  endfunction

  function automatic logic [17:0] conv(input logic [17:0] w, input logic f);
    return f ? (w ^ 18'h20000) : w;
  endfunction

  task automatic send_pair(input logic [17:0] iw, input logic [17:0] qw, input string tag);
    int v0;
    put_word(iw);
    v0 = vld_seen;
    put_word(qw);
    check(out_valid === 1'b1, "R5 valid after Q", int'(out_valid), 1);
    check(i_out === conv(iw, fmt_offset), tag, int'(i_out), int'(conv(iw, fmt_offset)));
    check(q_out === conv(qw, fmt_offset), tag, int'(q_out), int'(conv(qw, fmt_offset)));
    check(vld_seen == v0, "R5 no early valid", vld_seen, v0);
    @(negedge clk);
    check(out_valid === 1'b0, "R5 single pulse", int'(out_valid), 0);
    check(i_out === conv(iw, fmt_offset), "R10 hold", int'(i_out), int'(conv(iw, fmt_offset)));
  endtask

  initial begin
    rst_n = 1'b0;
    interp_r = 6'd2;
    fmt_offset = 1'b0;
    tx_en = 1'b0;
    data_in = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid === 1'b0 && orphan_err === 1'b0, "R9 flags in reset",
          int'({out_valid, orphan_err}), 0);
    check(word_ce === 1'b0, "R9 strobe in reset", int'(word_ce), 0);
    check(i_out === 18'h0 && q_out === 18'h0, "R9 data in reset", int'(i_out | q_out), 0);
    rst_n = 1'b1;

    // R1 / R2: strobe period sweep
    for (int r = 0; r <= 12; r++) check_period(r, (r < 2) ? 4 : 2 * r);
    check_period(63, 126);
    check_period(37, 74);

    // R4 R5 R6 R7: pair sweep over both formats and several factors
    for (int f = 0; f < 2; f++) begin
      fmt_offset = f[0];
      for (int r = 2; r <= 4; r++) begin
        interp_r = 6'(r);
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        for (int k = 0; k < 8; k++)
          send_pair(pick(k), pick(k + 9) ^ 18'h2A5A5, f[0] ? "R7 offset conv" : "R6 twos pass");
      end
    end

    // R3: words while tx_en low have no effect
    fmt_offset = 1'b0;
    interp_r = 6'd3;
    tx_en = 1'b0;
    begin
      int v0;
      int e0;
      v0 = vld_seen;
      e0 = err_seen;
      data_in = 18'h12345;
      repeat (30) @(negedge clk);
      check(vld_seen == v0, "R3 no capture when disabled", vld_seen, v0);
      check(err_seen == e0, "R3 no error when idle", err_seen, e0);
      check(i_out === conv(pick(7), 1'b1), "R3 outputs untouched", int'(i_out),
            int'(conv(pick(7), 1'b1)));
    end
    tx_en = 1'b1;
    send_pair(18'h0AAAA, 18'h15555, "R4 restart after idle");

    // R8: orphan I word
    begin
      int e0;
      put_word(18'h3C3C3);
      e0 = err_seen;
      tx_en = 1'b0;
      @(negedge clk);
      check(orphan_err === 1'b1, "R8 error pulse", int'(orphan_err), 1);
      @(negedge clk);
      check(orphan_err === 1'b0, "R8 error single", int'(orphan_err), 0);
      check(err_seen == e0 + 1, "R8 error count", err_seen, e0 + 1);
      check(i_out === 18'h0AAAA, "R8 orphan not output", int'(i_out), 18'h0AAAA);
      tx_en = 1'b1;
      send_pair(18'h01234, 18'h3FEDC, "R8 pair after orphan starts at I");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule